// File: doc/BRIEF.md
# Two-Bank Event Interrupt Aggregator

This block gathers single-cycle event pulses from the engines of a network controller (DMA completion, link changes, management-bus completion and error) into sticky status bits. It arranges them into banks of 32 sources, and each bank drives one level-sensitive interrupt line. A status bit stays set until software clears it. The line of a bank is high while any status bit whose mask bit is clear is set.

Software reaches each bank through six word registers on a simple write/read bus. Status and mask each have a read view, a write-one-to-set port and a write-one-to-clear port. This lets a handler raise an interrupt by itself, or mask and acknowledge sources, with no read-modify-write. The banks sit one above the other, `BANK_SPAN` bytes apart. Read data is combinational from the address.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 (masked), and every interrupt line is low.
- R2: A 1 on a bit of `evt_i` for one cycle sets the matching status bit at the next clock edge. The bit stays set until software clears it. Bank b, bit i is `evt_i[b*32+i]`.
- R3: A write to bank offset 0x04 sets the status bits where the data is 1 and leaves the others as they were.
- R4: A write to bank offset 0x08 clears the status bits where the data is 1 and leaves the others as they were.
- R5: When an event pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x10 sets the mask bits where the data is 1. A write to offset 0x14 clears the mask bits where the data is 1. Other mask bits keep their value.
- R7: `irq_o[b]` is high exactly when bank b has a status bit at 1 whose mask bit is 0. It follows the register state after the same edge that changes that state.
- R8: Bank 1 starts at byte 0x40. Its registers, events and line do not affect bank 0, and bank 0 does not affect bank 1.
- R9: Reads return the status at offset 0x00 and the mask at 0x0C, 0x10 and 0x14. Reads of 0x04, 0x08 and of unmapped addresses return 0.
- R10: Writes to offsets 0x00 and 0x0C, to offsets 0x18 and above within a bank, to addresses above the last bank, and to addresses that are not word aligned change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address and data |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | SRC_W | Write data; each 1 selects a bit |
| bus_rdata | output | SRC_W | Read data for `bus_addr`, combinational |
| evt_i | input | NUM_BANKS*SRC_W | Event pulses, bank-major |
| irq_o | output | NUM_BANKS | Level interrupt line per bank |

## Verification
The bench builds the block with its defaults: two banks of 32 sources, an 8-bit address and a 0x40 bank span. This covers the top source bit (31) of the upper bank and the seam between the two banks, and it leaves address 0x80 as an out-of-range bank index for the ignored-write case. The named controller sources (receive done, link up, management done and error) are driven at their fixed bit positions. The set-versus-clear collision is forced in a single cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    typedef enum logic [2:0] {
        SEL_RAW  = 3'd0,
        SEL_SSET = 3'd1,
        SEL_SCLR = 3'd2,
        SEL_MRD  = 3'd3,
        SEL_MSET = 3'd4,
        SEL_MCLR = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    // Source positions in bank 0
    localparam int SRC_LINK_UP   = 4;
    localparam int SRC_LINK_DOWN = 5;
    localparam int SRC_RX_DONE   = 13;
    localparam int SRC_TX_DONE   = 16;
    localparam int SRC_MGMT_DONE = 23;
    localparam int SRC_MGMT_ERR  = 24;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2,
    parameter int BANK_SPAN = 64
) (
    input  logic [ADDR_W-1:0]    addr,
    output reg_sel_e             sel,
    output logic [NUM_BANKS-1:0] bank_hit
);
    localparam int OFF_W = $clog2(BANK_SPAN);
    localparam int IDX_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0] offset;
    logic [IDX_W-1:0] bank_idx;
    reg_sel_e         sel_raw;

    assign offset   = addr[OFF_W-1:0];
    assign bank_idx = addr[ADDR_W-1:OFF_W];

    always_comb begin
        sel_raw = SEL_NONE;
        if (offset == OFF_W'(8'h00)) sel_raw = SEL_RAW;
        if (offset == OFF_W'(8'h04)) sel_raw = SEL_SSET;
        if (offset == OFF_W'(8'h08)) sel_raw = SEL_SCLR;
        if (offset == OFF_W'(8'h0C)) sel_raw = SEL_MRD;
        if (offset == OFF_W'(8'h10)) sel_raw = SEL_MSET;
        if (offset == OFF_W'(8'h14)) sel_raw = SEL_MCLR;
    end

    assign sel = sel_raw;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = (bank_idx == IDX_W'(b)) && (sel_raw != SEL_NONE);
    end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank
    import evt_irq_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [SRC_W-1:0] wdata,
    input  logic [SRC_W-1:0] evt,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] mask_o,
    output logic [SRC_W-1:0] rdata_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [SRC_W-1:0] status;
        logic [SRC_W-1:0] mask;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_SSET: st_d.status = st_q.status | wdata;
                SEL_SCLR: st_d.status = st_q.status & ~wdata;
                SEL_MSET: st_d.mask   = st_q.mask | wdata;
                SEL_MCLR: st_d.mask   = st_q.mask & ~wdata;
                default:  st_d = st_q;
            endcase
        end
        // Hardware events are merged last so they win over a clear
        st_d.status = st_d.status | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_RAW:                    rdata_o = st_q.status;
            SEL_MRD, SEL_MSET, SEL_MCLR: rdata_o = st_q.mask;
            default:                    rdata_o = '0;
        endcase
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/evt_irq_rdmux.sv
module evt_irq_rdmux #(
    parameter int SRC_W     = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic [NUM_BANKS-1:0]       bank_hit,
    input  logic [NUM_BANKS*SRC_W-1:0] bank_rdata,
    output logic [SRC_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) rdata = rdata | bank_rdata[b*SRC_W +: SRC_W];
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 8,
    parameter int BANK_SPAN = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [SRC_W-1:0]           bus_wdata,
    output logic [SRC_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] evt_i,
    output logic [NUM_BANKS-1:0]       irq_o
);
    localparam int TOT_W = NUM_BANKS * SRC_W;

    reg_sel_e             sel;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [TOT_W-1:0]     bank_rdata;
    logic [TOT_W-1:0]     status_all;
    logic [TOT_W-1:0]     mask_all;

    evt_irq_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .BANK_SPAN(BANK_SPAN)
    ) decode_i (
        .addr    (bus_addr),
        .sel     (sel),
        .bank_hit(bank_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        evt_irq_bank #(
            .SRC_W(SRC_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && bank_hit[b]),
            .sel     (sel),
            .wdata   (bus_wdata),
            .evt     (evt_i[b*SRC_W +: SRC_W]),
            .status_o(status_all[b*SRC_W +: SRC_W]),
            .mask_o  (mask_all[b*SRC_W +: SRC_W]),
            .rdata_o (bank_rdata[b*SRC_W +: SRC_W]),
            .irq_o   (irq_o[b])
        );
    end

    evt_irq_rdmux #(
        .SRC_W    (SRC_W),
        .NUM_BANKS(NUM_BANKS)
    ) rdmux_i (
        .bank_hit  (bank_hit),
        .bank_rdata(bank_rdata),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
    parameter int NUM_BANKS = 2,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 8,
    parameter int BANK_SPAN = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [SRC_W-1:0]           bus_rdata,
    input logic [NUM_BANKS*SRC_W-1:0] evt_i,
    input logic [NUM_BANKS-1:0]       irq_o,
    input logic [NUM_BANKS*SRC_W-1:0] status_all,
    input logic [NUM_BANKS*SRC_W-1:0] mask_all
);
    localparam int OFF_W = $clog2(BANK_SPAN);

    logic [OFF_W-1:0] offset;
    assign offset = bus_addr[OFF_W-1:0];

    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((status_all & $past(evt_i)) == $past(evt_i))); // R2

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_all & ~$past(status_all)) != '0) |-> ($past(bus_wr) || ($past(evt_i) != '0))); // R3

    AST_NO_SPONT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~status_all & $past(status_all)) != '0) |-> $past(bus_wr)); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask_all)); // R6

    AST_PORT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((offset == OFF_W'(8'h04)) || (offset == OFF_W'(8'h08))) |-> (bus_rdata == '0)); // R9

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_all[b*SRC_W +: SRC_W] == '1) |-> !irq_o[b]); // R7
    end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_BANKS(NUM_BANKS),
    .SRC_W    (SRC_W),
    .ADDR_W   (ADDR_W),
    .BANK_SPAN(BANK_SPAN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .status_all(status_all),
    .mask_all  (mask_all)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
    import evt_irq_pkg::*;

    localparam int NB = 2;
    localparam int SW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [SW-1:0] bus_wdata = '0;
    logic [SW-1:0] bus_rdata;
    logic [NB*SW-1:0] evt_i = '0;
    logic [NB-1:0] irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    evt_irq_ctrl #(
        .NUM_BANKS(NB),
        .SRC_W    (SW),
        .ADDR_W   (AW),
        .BANK_SPAN(64)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .evt_i    (evt_i),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [SW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [SW-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [NB*SW-1:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic cleanup();
        wr(8'h10, '1); wr(8'h08, '1);
        wr(8'h50, '1); wr(8'h48, '1);
    endtask

    task automatic t_reset();
        logic [SW-1:0] d;
        rd(8'h00, d); check("R1 bank0 status", d, 32'h0);
        rd(8'h0C, d); check("R1 bank0 mask", d, 32'hFFFF_FFFF);
        rd(8'h4C, d); check("R1 bank1 mask", d, 32'hFFFF_FFFF);
        check("R1 lines low", 32'(irq_o), 32'h0);
    endtask

    task automatic t_event_flow();
        logic [SW-1:0] d;
        cleanup();
        pulse((NB*SW)'(1) << SRC_RX_DONE);
        rd(8'h00, d); check("R2 rx done latched", d, 32'h0000_2000);
        check("R7 masked line low", 32'(irq_o[0]), 32'h0);
        wr(8'h14, 32'h0000_2000);
        rd(8'h0C, d); check("R6 mask clear one bit", d, 32'hFFFF_DFFF);
        check("R7 unmasked pending raises line", 32'(irq_o[0]), 32'h1);
        check("R8 other bank line low", 32'(irq_o[1]), 32'h0);
        wr(8'h08, 32'h0000_2000);
        rd(8'h00, d); check("R4 clear drops bit", d, 32'h0);
        check("R7 line low after clear", 32'(irq_o[0]), 32'h0);
        pulse((NB*SW)'(1) << SRC_RX_DONE);
        check("R2 second pulse raises line", 32'(irq_o[0]), 32'h1);
        wr(8'h10, 32'h0000_2000);
        check("R6 mask set drops line", 32'(irq_o[0]), 32'h0);
        rd(8'h00, d); check("R6 status kept while masked", d, 32'h0000_2000);
    endtask

    task automatic t_race();
        logic [SW-1:0] d;
        cleanup();
        pulse((NB*SW)'(1) << SRC_MGMT_ERR);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0180_0000;
        evt_i = (NB*SW)'(1) << SRC_MGMT_DONE;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_i = '0;
        rd(8'h00, d); check("R5 event wins over clear", d, 32'h0080_0000);
    endtask

    task automatic t_self_trigger();
        logic [SW-1:0] d;
        cleanup();
        wr(8'h04, 32'h0000_0010);
        check("R3 set while masked keeps line low", 32'(irq_o[0]), 32'h0);
        wr(8'h04, 32'h0000_0020);
        rd(8'h00, d); check("R3 set accumulates", d, 32'h0000_0030);
        wr(8'h14, 32'h0000_0010);
        check("R3 self trigger raises line", 32'(irq_o[0]), 32'h1);
    endtask

    task automatic t_reads();
        logic [SW-1:0] d;
        cleanup();
        wr(8'h04, 32'hA5A5_0000);
        wr(8'h14, 32'h0000_00FF);
        rd(8'h04, d); check("R9 set port reads zero", d, 32'h0);
        rd(8'h08, d); check("R9 clear port reads zero", d, 32'h0);
        rd(8'h10, d); check("R9 mask set port reads mask", d, 32'hFFFF_FF00);
        rd(8'h14, d); check("R9 mask clear port reads mask", d, 32'hFFFF_FF00);
        rd(8'h18, d); check("R9 unmapped reads zero", d, 32'h0);
    endtask

    task automatic t_bank1();
        logic [SW-1:0] d;
        cleanup();
        pulse((NB*SW)'(1) << (SW + 31));
        rd(8'h40, d); check("R8 bank1 status bit31", d, 32'h8000_0000);
        rd(8'h00, d); check("R8 bank0 untouched", d, 32'h0);
        wr(8'h54, 32'h8000_0000);
        check("R8 bank1 line high", 32'(irq_o[1]), 32'h1);
        check("R8 bank0 line low", 32'(irq_o[0]), 32'h0);
        rd(8'h4C, d); check("R8 bank1 mask", d, 32'h7FFF_FFFF);
        rd(8'h0C, d); check("R8 bank0 mask intact", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_ignored();
        logic [SW-1:0] d;
        cleanup();
        wr(8'h04, 32'h0000_0001);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h96, 32'h0);
        wr(8'h05, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R10 bank0 status unchanged", d, 32'h0000_0001);
        rd(8'h0C, d); check("R10 bank0 mask unchanged", d, 32'hFFFF_FFFF);
        rd(8'h40, d); check("R10 bank1 status unchanged", d, 32'h0);
        rd(8'h4C, d); check("R10 bank1 mask unchanged", d, 32'hFFFF_FFFF);
        check("R10 lines low", 32'(irq_o), 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event_flow();
        t_race();
        t_self_trigger();
        t_reads();
        t_bank1();
        t_ignored();
        cleanup();
        check("R1 lines low after flush", 32'(irq_o), 32'h0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end
endmodule